// File: doc/BRIEF.md
# Byte-Lane Delay Window Sweep Engine

This engine finds the range of delay-tap settings over which each of several byte lanes transfers data correctly. It moves one shared 5-bit tap across its full range, one step at a time, and offers that tap to every lane that has not yet closed its window. At each tap it asks an external pattern checker for a verdict. It makes three requests per tap and ORs the three per-lane fail masks together. Each lane runs its own three-state tracker: no pass seen yet, passing, and closed. The tracker records where the window opens and where it closes. It throws away a pass that proves too narrow, because such a pass is treated as a false pass.

A run consists of eight sweeps, one for each victim-bit pattern that the checker selects. The stored limits carry over from one sweep to the next, so the result is the overlap of all eight windows. Receive runs sweep the tap upward from 0. Transmit runs sweep downward from 31. A single-lane mode limits the run to lane 0, for use with the check-byte lane. A lane that never passes in a sweep ends the run with a range error.

The request channel is valid/ready. `req_valid` rises with `tap` and `lane_act` already valid. All three stay stable until the checker takes the request by raising `req_ready` in the same cycle. After a request is accepted the engine waits for exactly one response, a single-cycle `rsp_valid` carrying `rsp_fail`. The engine can always take the response while it is waiting. The checker can throttle the engine by holding `req_ready` low or by delaying its response.

Top module: `dly_window_sweep`

## Requirements
- R1: A receive run (`tx_mode`=0) starts every sweep at tap 0 and raises the tap by exactly 1 between taps. A transmit run starts at tap 31 and lowers it by 1.
- R2: The engine issues three requests at each tap. A lane counts as failing that tap if any of the three `rsp_fail` bits for it is 1.
- R3: When a lane with no pass seen gets a passing tap, it enters the passing state and records the window opening. In receive the tap becomes the low limit if the tap is at or above the stored low limit. In transmit the tap becomes the high limit if the tap is at or below the stored high limit.
- R4: When a passing lane fails a tap, it forms a candidate window. In receive the candidate high limit is tap−1 and the low limit is the stored one. In transmit the candidate low limit is tap+1 and the high limit is the stored one. If the candidate does not tighten the stored limit, or if it has low ≤ high and high−low ≥ MIN_W (default 4), the lane closes. Closing stores the candidate when it tightens the limit and drops the lane's bit from `lane_act`.
- R5: A candidate with low > high, or with high−low < MIN_W, is rejected. The lane returns to the no-pass state and keeps sweeping, and a later pass reopens the window.
- R6: A sweep stops at the first tap after which no lane is still active. The next sweep, or the end of the run, follows at once.
- R7: A run has eight sweeps. The limits are kept between sweeps, so the final limits are the overlap of the per-sweep windows.
- R8: If a sweep reaches its last tap while an active lane is still in the no-pass state, the run ends. `range_err` is set, that lane's `lane_err` bit is set, and its low limit reads 63. A lane still passing at the last tap keeps its limits and raises no error.
- R9: When `single_lane` is 1 at start, only lane 0 is ever active. The limits of the other lanes stay at 0 and 31.
- R10: Reset and every accepted `start` set each lane's limits to low 0 and high 31 and clear `range_err` and `lane_err`.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `tap` and `lane_act` hold their values.
- R12: `busy` is high from the cycle after an accepted `start` until the run ends. `done` then stays high until the next `start`, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| tx_mode | input | 1 | 0 selects the upward receive sweep, 1 the downward transmit sweep |
| single_lane | input | 1 | Restrict the run to lane 0 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| range_err | output | 1 | Run ended because a lane never passed |
| lane_err | output | LANES | Lanes that caused the range error |
| tap | output | TAP_W | Delay tap offered with the current request |
| lane_act | output | LANES | Lanes still sweeping (request lane mask) |
| req_valid | output | 1 | Compare request valid |
| req_ready | input | 1 | Checker accepts the request |
| rsp_valid | input | 1 | One-cycle compare response |
| rsp_fail | input | LANES | Per-lane fail bits of the response |
| win_lo | output | LANES*(TAP_W+1) | Per-lane low limits, lane i at bits [i*6 +: 6] |
| win_hi | output | LANES*(TAP_W+1) | Per-lane high limits, lane i at bits [i*6 +: 6] |

## Verification
On every cycle the assertions check several local rules:
- the request holds still under back-pressure;
- the tap moves one step in the mode's direction each time a new tap is offered;
- a lane closes only on a failing tap, and only a passing tap opens it;
- a closed lane stays closed until the next sweep;
- an error lane carries the 63 marker;
- a finished run holds `done`.

Some behaviour shows only across whole runs, and the bench's scenarios cover it. Those runs check the exact limit values produced by the window arithmetic, the rejection of a one-tap false pass, the effect of ORing the three compares, the overlap across eight varying sweeps, the early end of a sweep seen in the request count, and the range error that stops a run after a single sweep.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    LN_NOPASS = 2'd0,
    LN_OPEN   = 2'd1,
    LN_CLOSED = 2'd2
  } lane_st_t;

  typedef enum logic [2:0] {
    EN_IDLE  = 3'd0,
    EN_PINIT = 3'd1,
    EN_CMP   = 3'd2,
    EN_EVAL  = 3'd3,
    EN_DONE  = 3'd4
  } eng_st_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/sweep_cmp_seq.sv
module sweep_cmp_seq
  import sweep_pkg::*;
#(
  parameter int LANES  = 9,
  parameter int REPEAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [LANES-1:0] rsp_fail,
  output logic             seq_done,
  output logic [LANES-1:0] fail_acc
);
  localparam int CNT_W = $clog2(REPEAT + 1);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx    = cnt_q + 1'b1;
  assign req_valid = (st_q == SQ_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      fail_acc <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (go) begin
            fail_acc <= '0;
            cnt_q    <= '0;
            st_q     <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (req_ready) st_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (rsp_valid) begin
            fail_acc <= fail_acc | rsp_fail;
            cnt_q    <= cnt_nx;
            if (cnt_nx == CNT_W'(REPEAT)) begin
              seq_done <= 1'b1;
              st_q     <= SQ_IDLE;
            end else begin
              st_q <= SQ_ISSUE;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R2: a verdict only follows an accepted response
  assert_done_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(rsp_valid));
endmodule

// File: rtl/sweep_lane.sv
module sweep_lane
  import sweep_pkg::*;
#(
  parameter int TAP_W = 5,
  parameter int MIN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_lim,
  input  logic               pass_init,
  input  logic               en,
  input  logic               upd,
  input  logic               fail,
  input  logic               mark_err,
  input  logic               tx,
  input  logic [TAP_W-1:0]   tap,
  output logic [TAP_W:0]     lo,
  output logic [TAP_W:0]     hi,
  output logic               active,
  output logic               in_nopass,
  output logic               err
);
  localparam int LIM_W = TAP_W + 1;
  localparam logic [LIM_W-1:0] TOP  = LIM_W'((1 << TAP_W) - 1);
  localparam logic [LIM_W-1:0] MARK = {LIM_W{1'b1}};

  lane_st_t         st_q;
  logic [LIM_W-1:0] tap_x, cand_lo, cand_hi, wide;
  logic             tighten, ok;

  always_comb begin
    tap_x = LIM_W'(tap);
    if (tx) begin
      cand_lo = tap_x + 1'b1;
      cand_hi = hi;
      tighten = lo < cand_lo;
    end else begin
      cand_lo = lo;
      cand_hi = tap_x - 1'b1;
      tighten = hi > cand_hi;
    end
    wide = cand_hi - cand_lo;
    ok   = !tighten || ((cand_lo <= cand_hi) && (wide >= LIM_W'(MIN_W)));
  end

  assign in_nopass = (st_q == LN_NOPASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo     <= '0;
      hi     <= TOP;
      st_q   <= LN_NOPASS;
      active <= 1'b0;
      err    <= 1'b0;
    end else if (clr_lim) begin
      lo     <= '0;
      hi     <= TOP;
      st_q   <= LN_NOPASS;
      active <= 1'b0;
      err    <= 1'b0;
    end else if (pass_init) begin
      st_q   <= LN_NOPASS;
      active <= en;
    end else if (mark_err) begin
      err <= 1'b1;
      lo  <= MARK;
    end else if (upd && active) begin
      if (fail) begin
        if (st_q == LN_OPEN) begin
          if (ok) begin
            if (tighten) begin
              lo <= cand_lo;
              hi <= cand_hi;
            end
            st_q   <= LN_CLOSED;
            active <= 1'b0;
          end else begin
            st_q <= LN_NOPASS;
          end
        end
      end else if (st_q == LN_NOPASS) begin
        st_q <= LN_OPEN;
        if (tx) begin
          if (hi >= tap_x) hi <= tap_x;
        end else begin
          if (lo <= tap_x) lo <= tap_x;
        end
      end
    end
  end

  // R4: a lane closes only on a failing tap
  assert_close_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(active) && !active) |-> $past(fail));

  // R4: a closed lane stays closed until a new sweep or run
  assert_closed_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_CLOSED && !pass_init && !clr_lim) |=> (st_q == LN_CLOSED));

  // R3: the window opens only on a passing tap
  assert_open_on_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_OPEN && $past(st_q) != LN_OPEN) |-> !$past(fail));

  // R8: an error lane reads the illegal marker
  assert_err_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (lo == MARK));
endmodule

// File: rtl/dly_window_sweep.sv
module dly_window_sweep
  import sweep_pkg::*;
#(
  parameter int LANES  = 9,
  parameter int TAP_W  = 5,
  parameter int REPEAT = 3,
  parameter int PASSES = 8,
  parameter int MIN_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         tx_mode,
  input  logic                         single_lane,
  output logic                         busy,
  output logic                         done,
  output logic                         range_err,
  output logic [LANES-1:0]             lane_err,
  output logic [TAP_W-1:0]             tap,
  output logic [LANES-1:0]             lane_act,
  output logic                         req_valid,
  input  logic                         req_ready,
  input  logic                         rsp_valid,
  input  logic [LANES-1:0]             rsp_fail,
  output logic [LANES*(TAP_W+1)-1:0]   win_lo,
  output logic [LANES*(TAP_W+1)-1:0]   win_hi
);
  localparam int LIM_W  = TAP_W + 1;
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  eng_st_t          st_q;
  logic [TAP_W-1:0] tap_q;
  logic             tx_q, single_q, rerr_q;
  logic [PASS_W-1:0] pass_q;

  logic [LANES-1:0] en_w, act_w, nopass_w, err_w, mark_w, fail_acc;
  logic             launch, pass_init, upd, at_end, stuck, step, last_pass;
  logic             in_eval, seq_go, seq_done;

  assign launch    = start && (st_q == EN_IDLE || st_q == EN_DONE);
  assign pass_init = (st_q == EN_PINIT);
  assign upd       = (st_q == EN_CMP) && seq_done;
  assign in_eval   = (st_q == EN_EVAL);
  assign at_end    = tx_q ? (tap_q == '0) : (tap_q == TAP_MAX);
  assign stuck     = |(act_w & nopass_w);
  assign step      = in_eval && (act_w != '0) && !at_end;
  assign last_pass = (pass_q == PASS_W'(PASSES - 1));
  assign mark_w    = (in_eval && at_end && (act_w != '0)) ? (act_w & nopass_w) : '0;
  assign seq_go    = pass_init || step;
  assign en_w      = single_q ? LANES'(1) : {LANES{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= EN_IDLE;
      tap_q    <= '0;
      tx_q     <= 1'b0;
      single_q <= 1'b0;
      rerr_q   <= 1'b0;
      pass_q   <= '0;
    end else begin
      case (st_q)
        EN_IDLE, EN_DONE: begin
          if (launch) begin
            tx_q     <= tx_mode;
            single_q <= single_lane;
            rerr_q   <= 1'b0;
            pass_q   <= '0;
            st_q     <= EN_PINIT;
          end
        end
        EN_PINIT: begin
          tap_q <= tx_q ? TAP_MAX : '0;
          st_q  <= EN_CMP;
        end
        EN_CMP: begin
          if (seq_done) st_q <= EN_EVAL;
        end
        EN_EVAL: begin
          if (act_w == '0 || at_end) begin
            if (act_w != '0 && stuck) begin
              rerr_q <= 1'b1;
              st_q   <= EN_DONE;
            end else if (last_pass) begin
              st_q <= EN_DONE;
            end else begin
              pass_q <= pass_q + 1'b1;
              st_q   <= EN_PINIT;
            end
          end else begin
            tap_q <= tx_q ? (tap_q - 1'b1) : (tap_q + 1'b1);
            st_q  <= EN_CMP;
          end
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  sweep_cmp_seq #(
    .LANES  (LANES),
    .REPEAT (REPEAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (seq_go),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail),
    .seq_done  (seq_done),
    .fail_acc  (fail_acc)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sweep_lane #(
      .TAP_W (TAP_W),
      .MIN_W (MIN_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_lim   (launch),
      .pass_init (pass_init),
      .en        (en_w[i]),
      .upd       (upd),
      .fail      (fail_acc[i]),
      .mark_err  (mark_w[i]),
      .tx        (tx_q),
      .tap       (tap_q),
      .lo        (win_lo[i*LIM_W +: LIM_W]),
      .hi        (win_hi[i*LIM_W +: LIM_W]),
      .active    (act_w[i]),
      .in_nopass (nopass_w[i]),
      .err       (err_w[i])
    );
  end

  assign busy      = (st_q == EN_PINIT) || (st_q == EN_CMP) || (st_q == EN_EVAL);
  assign done      = (st_q == EN_DONE);
  assign range_err = rerr_q;
  assign lane_err  = err_w;
  assign tap       = tap_q;
  assign lane_act  = act_w;

  // R11: request fields hold under back-pressure
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(tap) && $stable(lane_act)));

  // R1: a new tap is one step away in the mode's direction
  assert_tap_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EN_CMP && $past(st_q) == EN_EVAL) |->
      (tx_q ? (tap_q == $past(tap_q) - 1'b1) : (tap_q == $past(tap_q) + 1'b1)));

  // R12: a finished run holds done until the next start
  assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/dly_window_sweep_tb_top.sv
module dly_window_sweep_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;
  localparam int V = 8;
  localparam int RUN_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tx_mode = 1'b0, single_lane = 1'b0;
  logic busy, done, range_err, req_valid;
  logic req_ready, rsp_valid;
  logic [N-1:0] lane_err, lane_act, rsp_fail;
  logic [4:0] tap;
  logic [N*6-1:0] win_lo, win_hi;

  int n_chk = 0, n_bad = 0;
  int wlo [N][V];
  int whi [N][V];
  int glitch [N];
  int flaky [N];
  bit dead [N];
  int nreq, victim, prev_tap, first_tap, step_bad, start_tap_b;
  logic [N-1:0] act_or;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_window_sweep dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_mode(tx_mode),
    .single_lane(single_lane), .busy(busy), .done(done),
    .range_err(range_err), .lane_err(lane_err), .tap(tap),
    .lane_act(lane_act), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .win_lo(win_lo), .win_hi(win_hi)
  );

  function automatic logic lane_fails(int l, int t, int v, int r);
    if (dead[l]) return 1'b1;
    if (t == glitch[l]) return 1'b0;
    if (t == flaky[l] && r == 1) return 1'b1;
    return !(t >= wlo[l][v] && t <= whi[l][v]);
  endfunction

  function automatic int lo_of(int l);
    return int'(win_lo[l*6 +: 6]);
  endfunction

  function automatic int hi_of(int l);
    return int'(win_hi[l*6 +: 6]);
  endfunction

  // checker model: throttles ready, answers each accepted request once
  initial begin : responder
    int tick;
    tick = 0;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_fail  = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      tick++;
      req_ready = (tick % 3) != 1;
      if (req_valid && req_ready) begin
        int r, t;
        logic [N-1:0] f;
        t = int'(tap);
        r = nreq % 3;
        if (nreq == 0) begin
          victim = 0;
          first_tap = t;
        end else if (r == 0 && t == start_tap_b) begin
          if (victim < V - 1) victim++;
        end else if (r == 0) begin
          if (t != prev_tap + ((start_tap_b == 0) ? 1 : -1)) step_bad++;
        end else begin
          if (t != prev_tap) step_bad++;
        end
        prev_tap = t;
        act_or = act_or | lane_act;
        for (int l = 0; l < N; l++) f[l] = lane_fails(l, t, victim, r);
        nreq++;
        @(negedge clk);
        req_ready = 1'b0;
        if (nreq % 2 == 0) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_fail  = f;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_all(int lo, int hi);
    for (int l = 0; l < N; l++) begin
      for (int v = 0; v < V; v++) begin
        wlo[l][v] = lo;
        whi[l][v] = hi;
      end
      glitch[l] = -1;
      flaky[l]  = -1;
      dead[l]   = 1'b0;
    end
  endtask

  task automatic run(logic tx, logic single);
    int cyc;
    nreq = 0;
    step_bad = 0;
    act_or = '0;
    start_tap_b = tx ? 31 : 0;
    @(negedge clk);
    tx_mode = tx;
    single_lane = single;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_up();
    end
    chk("R12 busy low at done", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset done", int'(done), 0);
    chk("R10 reset range_err", int'(range_err), 0);
    chk("R10 reset lo", lo_of(0), 0);
    chk("R10 reset hi", hi_of(4), 31);
    chk("R11 reset req_valid", int'(req_valid), 0);
  endtask

  task automatic t_rx_basic();
    set_all(0, 0);
    for (int l = 0; l < N; l++)
      for (int v = 0; v < V; v++) begin wlo[l][v] = l + 3; whi[l][v] = l + 15; end
    run(1'b0, 1'b0);
    chk("R1 rx first tap", first_tap, 0);
    chk("R1 rx step", step_bad, 0);
    for (int l = 0; l < N; l++) begin
      chk("R3 rx low", lo_of(l), l + 3);
      chk("R4 rx high", hi_of(l), l + 15);
    end
    chk("R6 rx early stop count", nreq, 25 * 3 * 8);
    chk("R8 rx no error", int'(range_err), 0);
  endtask

  task automatic t_tx_basic();
    set_all(0, 0);
    for (int l = 0; l < N; l++)
      for (int v = 0; v < V; v++) begin wlo[l][v] = l + 3; whi[l][v] = l + 15; end
    run(1'b1, 1'b0);
    chk("R1 tx first tap", first_tap, 31);
    chk("R1 tx step", step_bad, 0);
    for (int l = 0; l < N; l++) begin
      chk("R3 tx high", hi_of(l), l + 15);
      chk("R4 tx low", lo_of(l), l + 3);
    end
    chk("R6 tx early stop count", nreq, 30 * 3 * 8);
  endtask

  task automatic t_overlap();
    set_all(0, 0);
    for (int l = 0; l < N; l++)
      for (int v = 0; v < V; v++) begin wlo[l][v] = 4 + v; whi[l][v] = 24 - v; end
    run(1'b0, 1'b0);
    chk("R7 overlap low", lo_of(3), 11);
    chk("R7 overlap high", hi_of(3), 17);
    chk("R7 overlap low lane 8", lo_of(8), 11);
  endtask

  task automatic t_false_pass();
    set_all(3, 15);
    for (int v = 0; v < V; v++) begin wlo[0][v] = 10; whi[0][v] = 25; end
    glitch[0] = 2;
    run(1'b0, 1'b0);
    chk("R5 false pass low", lo_of(0), 10);
    chk("R5 false pass high", hi_of(0), 25);
    chk("R5 neighbour lane", hi_of(1), 15);
  endtask

  task automatic t_or_repeat();
    set_all(3, 15);
    for (int v = 0; v < V; v++) begin wlo[1][v] = 5; whi[1][v] = 20; end
    flaky[1] = 8;
    run(1'b0, 1'b0);
    chk("R2 second compare fail low", lo_of(1), 9);
    chk("R2 second compare fail high", hi_of(1), 20);
  endtask

  task automatic t_range_err();
    set_all(3, 15);
    dead[2] = 1'b1;
    run(1'b0, 1'b0);
    chk("R8 range_err", int'(range_err), 1);
    chk("R8 lane_err mask", int'(lane_err), 4);
    chk("R8 marker", lo_of(2), 63);
    chk("R8 good lane low", lo_of(0), 3);
    chk("R8 stop after one sweep", nreq, 32 * 3);
  endtask

  task automatic t_single();
    set_all(0, 2);
    for (int v = 0; v < V; v++) begin wlo[0][v] = 6; whi[0][v] = 14; end
    run(1'b0, 1'b1);
    chk("R10 range_err cleared", int'(range_err), 0);
    chk("R10 lane_err cleared", int'(lane_err), 0);
    chk("R9 only lane 0 offered", int'(act_or), 1);
    chk("R9 lane 0 low", lo_of(0), 6);
    chk("R9 lane 0 high", hi_of(0), 14);
    chk("R9 lane 1 low untouched", lo_of(1), 0);
    chk("R9 lane 1 high untouched", hi_of(1), 31);
  endtask

  task automatic t_end_open();
    set_all(20, 31);
    run(1'b0, 1'b0);
    chk("R8 open at end no error", int'(range_err), 0);
    chk("R8 open at end low", lo_of(5), 20);
    chk("R8 open at end high", hi_of(5), 31);
    chk("R7 full sweeps count", nreq, 32 * 3 * 8);
    chk("R12 done held", int'(done), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_overlap();
    t_false_pass();
    t_or_repeat();
    t_range_err();
    t_single();
    t_end_open();
    finish_up();
  end
endmodule